// File: doc/BRIEF.md
# Triple-Copy Voting RAM with Repair Sweep

This block is a single-port synchronous RAM that keeps every word in three identical copies. It is meant for memories that have no built-in error correction. A write lands in all three copies. A read returns the bitwise majority of the three copies one cycle later, so a flipped or stuck bit in any one copy never reaches the reader.

Whenever the three words presented to the voter disagree, the block raises an error flag for that cycle and bumps a saturating counter. At the end of that cycle it writes the voted word back into all three copies at that address, which repairs the diverging copy. Reads that the user issues trigger this repair. So do reads from a background sweeper, which uses every idle cycle to visit the addresses in ascending order.

A fault-injection input can flip chosen bits of one copy. This lets the repair path be exercised on purpose.

Top module: `tmr_scrub_ram`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` into all three copies at `addr`. A read (`rd_en`=1, `wr_en`=0) presents its result on `rd_data` with `rd_valid`=1 exactly one cycle later.
- R2: `rd_data` is the bitwise majority of the three copies. While `flip_en`=1 with `wr_en`=`rd_en`=0, the bits set in `flip_mask` are inverted in copy `flip_sel` (0, 1 or 2; the value 3 selects no copy) at `addr`, and a read of that word still returns the stored value.
- R3: `err` is high for exactly the cycle in which a voted word whose three copies disagree is presented. This applies to user reads and sweep reads alike.
- R4: At the end of a cycle with `err`=1, the voted word is written into all three copies at that word's address. A later corruption of a different copy at the same bits is then still outvoted.
- R5: When a user write targets that same address in that cycle, the user write takes precedence and no write-back occurs.
- R6: A read of the address that is being repaired in the same cycle returns the repaired word and does not raise `err` again.
- R7: In every cycle with `wr_en`, `rd_en` and `flip_en` all low, the sweeper reads the next address in ascending order, wrapping from DEPTH-1 to 0. `sweep_busy` is high in the cycle after such a read, when its word is at the voter.
- R8: The sweeper stalls during any user cycle (write, read or flip) and resumes at the same address.
- R9: `err_cnt` increases by one after each cycle with `err`=1 and saturates at 2^CNT_W-1.
- R10: Reset clears all copies to zero, `err_cnt` to zero, `rd_valid` and `sweep_busy` to zero, and points the sweeper at address 0.
- R11: With `wr_en` and `rd_en` both high, only the write is performed and `rd_valid` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address for write, read or flip |
| wr_data | input | DW | Write data |
| wr_en | input | 1 | Write all three copies |
| rd_en | input | 1 | Read with majority vote |
| flip_en | input | 1 | Fault injection: invert bits of one copy |
| flip_sel | input | 2 | Copy to corrupt (0..2, 3 = none) |
| flip_mask | input | DW | Bits to invert |
| rd_data | output | DW | Voted read data |
| rd_valid | output | 1 | rd_data holds a user read result |
| err | output | 1 | Copies disagreed on the presented word |
| err_cnt | output | CNT_W | Saturating count of corrected words |
| sweep_busy | output | 1 | A sweep read is at the voter |

## Verification
On every cycle, the assertions check several properties: the one-cycle read response, the suppression of a read when a write is issued with it, that `err` only accompanies a word actually at the voter, the counter's step-or-hold behaviour, and the sweeper's wrap and stall. Other behaviours can only be shown by the bench's scenarios, which inject flips and then read. These are whether voting really masks a corrupted copy, whether the write-back repairs it (proven by corrupting a second copy afterwards), the same-cycle forwarding on a back-to-back read, the order in which the sweep reaches a corrupted word, and counter saturation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCOPY = 3;

    typedef enum logic {
        SRC_USER  = 1'b0,
        SRC_SWEEP = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_FLIP  = 2'd3
    } op_e;

    function automatic op_e decode_op(input logic w, input logic r, input logic f);
        if (w)      return OP_WRITE;
        else if (r) return OP_READ;
        else if (f) return OP_FLIP;
        else        return OP_IDLE;
    endfunction

endpackage

// File: rtl/tmr_copy_bank.sv
module tmr_copy_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          usr_we,
    input  logic [AW-1:0] usr_addr,
    input  logic [DW-1:0] usr_data,
    input  logic          fix_we,
    input  logic [AW-1:0] fix_addr,
    input  logic [DW-1:0] fix_data,
    input  logic          flip_we,
    input  logic [DW-1:0] flip_mask,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    input  logic          fwd_en,
    input  logic [DW-1:0] fwd_data,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] cells [DEPTH];

    // Priority per cell: user write over repair, repair over flip (last NBA wins).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            rd_q <= '0;
        end else begin
            if (flip_we) cells[usr_addr] <= cells[usr_addr] ^ flip_mask;
            if (fix_we)  cells[fix_addr] <= fix_data;
            if (usr_we)  cells[usr_addr] <= usr_data;
            if (rd_go)   rd_q <= fwd_en ? fwd_data : cells[rd_addr];
        end
    end

    // R6
    fwd_use_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && fwd_en) |=> rd_q == $past(fwd_data));
endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] q0,
    input  logic [DW-1:0] q1,
    input  logic [DW-1:0] q2,
    output logic [DW-1:0] voted,
    output logic          differ
);
    always_comb begin
        for (int b = 0; b < DW; b++) begin
            voted[b] = (q0[b] & q1[b]) | (q0[b] & q2[b]) | (q1[b] & q2[b]);
        end
        differ = (q0 != q1) || (q1 != q2);
    end

    // R2
    vote_agree_chk: assert final (differ || (voted == q0));
endmodule

// File: rtl/tmr_scrubber.sv
module tmr_scrubber #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    output logic          issue,
    output logic [AW-1:0] scan_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign issue = idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_addr <= '0;
        end else if (issue) begin
            scan_addr <= (scan_addr == LAST) ? '0 : scan_addr + 1'b1;
        end
    end

    // R7
    scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && scan_addr == LAST) |=> scan_addr == '0);
    // R7
    scan_move_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && scan_addr != LAST) |=> scan_addr != $past(scan_addr));
    // R8
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(scan_addr));
endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram
    import tmr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CNT_W = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             flip_en,
    input  logic [1:0]       flip_sel,
    input  logic [DW-1:0]    flip_mask,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             err,
    output logic [CNT_W-1:0] err_cnt,
    output logic             sweep_busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic          valid;
        src_e          src;
        logic [AW-1:0] addr;
    } stage_t;

    op_e           op;
    stage_t        stage;
    logic          idle, sw_issue, rd_go, fix_we, fwd_en;
    logic [AW-1:0] sw_addr, rd_addr;
    logic [DW-1:0] voted;
    logic          differ;
    logic [DW-1:0] copy_q [NCOPY];

    assign op   = decode_op(wr_en, rd_en, flip_en);
    assign idle = (op == OP_IDLE);

    tmr_scrubber #(.DEPTH(DEPTH)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .issue     (sw_issue),
        .scan_addr (sw_addr)
    );

    assign rd_go   = (op == OP_READ) || sw_issue;
    assign rd_addr = (op == OP_READ) ? addr : sw_addr;

    // Voted word at the stage: flag and repair unless a user write claims the address.
    assign err    = stage.valid && differ;
    assign fix_we = err && !(wr_en && addr == stage.addr);
    assign fwd_en = fix_we && (rd_addr == stage.addr);

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        tmr_copy_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .usr_we    (op == OP_WRITE),
            .usr_addr  (addr),
            .usr_data  (wr_data),
            .fix_we    (fix_we),
            .fix_addr  (stage.addr),
            .fix_data  (voted),
            .flip_we   ((op == OP_FLIP) && (flip_sel == 2'(k))),
            .flip_mask (flip_mask),
            .rd_go     (rd_go),
            .rd_addr   (rd_addr),
            .fwd_en    (fwd_en),
            .fwd_data  (voted),
            .rd_q      (copy_q[k])
        );
    end

    tmr_voter #(.DW(DW)) u_vote (
        .q0     (copy_q[0]),
        .q1     (copy_q[1]),
        .q2     (copy_q[2]),
        .voted  (voted),
        .differ (differ)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage   <= '{valid: 1'b0, src: SRC_USER, addr: '0};
            err_cnt <= '0;
        end else begin
            stage.valid <= rd_go;
            stage.src   <= (op == OP_READ) ? SRC_USER : SRC_SWEEP;
            stage.addr  <= rd_addr;
            if (err && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
        end
    end

    assign rd_data    = voted;
    assign rd_valid   = stage.valid && (stage.src == SRC_USER);
    assign sweep_busy = stage.valid && (stage.src == SRC_SWEEP);

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> rd_valid);
    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_valid && !sweep_busy);
    // R3
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (rd_valid || sweep_busy));
    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (err && err_cnt != CNT_MAX) |=> err_cnt == $past(err_cnt) + 1'b1);
    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!err || err_cnt == CNT_MAX) |=> $stable(err_cnt));
endmodule

// File: tb/tb_tmr_scrub_ram.sv
`timescale 1ns/1ps
module tb_tmr_scrub_ram;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int CNT_W = 3;
    localparam int AW    = 3;
    localparam int CMAX  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0, flip_mask = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, flip_en = 1'b0;
    logic [1:0] flip_sel = 2'd3;
    logic [DW-1:0] rd_data;
    logic rd_valid, err, sweep_busy;
    logic [CNT_W-1:0] err_cnt;

    always #2.5 clk = ~clk;

    tmr_scrub_ram #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .flip_en(flip_en), .flip_sel(flip_sel), .flip_mask(flip_mask),
        .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .err_cnt(err_cnt),
        .sweep_busy(sweep_busy)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] maj3(input logic [DW-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Behavioural reference model
    logic [DW-1:0] rm [3][DEPTH];
    logic [DW-1:0] rq [3];
    bit  m_valid, m_sweep;
    int  m_addr, m_cnt, m_ptr;

    always @(posedge clk) begin : model
        logic [DW-1:0] v;
        bit mis, fix, rd, rsrc;
        int ra;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                rq[k] = '0;
                for (int i = 0; i < DEPTH; i++) rm[k][i] = '0;
            end
            m_valid = 0; m_sweep = 0; m_addr = 0; m_cnt = 0; m_ptr = 0;
        end else begin
            v   = maj3(rq[0], rq[1], rq[2]);
            mis = m_valid && (rq[0] != rq[1] || rq[1] != rq[2]);
            fix = mis && !(wr_en && int'(addr) == m_addr);
            rd = 0; ra = 0; rsrc = 0;
            if (!wr_en && rd_en) begin
                rd = 1; ra = int'(addr);
            end else if (!wr_en && !rd_en && !flip_en) begin
                rd = 1; ra = m_ptr; rsrc = 1; m_ptr = (m_ptr + 1) % DEPTH;
            end
            if (rd)
                for (int k = 0; k < 3; k++) rq[k] = (fix && ra == m_addr) ? v : rm[k][ra];
            if (flip_en && !wr_en && !rd_en && flip_sel != 2'd3)
                rm[flip_sel][addr] = rm[flip_sel][addr] ^ flip_mask;
            if (fix) for (int k = 0; k < 3; k++) rm[k][m_addr] = v;
            if (wr_en) for (int k = 0; k < 3; k++) rm[k][addr] = wr_data;
            if (mis && m_cnt < CMAX) m_cnt++;
            m_valid = rd; m_sweep = rsrc; m_addr = ra;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_err;
            e_err = m_valid && (rq[0] != rq[1] || rq[1] != rq[2]);
            chk("R1 model rd_valid", rd_valid, m_valid && !m_sweep);
            chk("R3 model err", err, e_err);
            chk("R7 model sweep_busy", sweep_busy, m_valid && m_sweep);
            chk("R9 model err_cnt", err_cnt, m_cnt);
            if (m_valid && !m_sweep) chk("R2 model rd_data", rd_data, maj3(rq[0], rq[1], rq[2]));
        end
    end

    task automatic step(input logic w, r, f, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [1:0] s, input logic [DW-1:0] m);
        wr_en = w; rd_en = r; flip_en = f; addr = a; wr_data = d; flip_sel = s; flip_mask = m;
        @(negedge clk);
    endtask
    task automatic do_idle();                       step(0, 0, 0, '0, '0, 2'd3, '0); endtask
    task automatic do_write(input int a, input int d); step(1, 0, 0, AW'(a), DW'(d), 2'd3, '0); endtask
    task automatic do_read(input int a);            step(0, 1, 0, AW'(a), '0, 2'd3, '0); endtask
    task automatic do_flip(input int a, input int s, input int m);
        step(0, 0, 1, AW'(a), '0, 2'(s), DW'(m));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int pulses;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 rd_valid after reset", rd_valid, 0);
        chk("R10 err_cnt after reset", err_cnt, 0);
        chk("R10 sweep_busy after reset", sweep_busy, 0);

        // R8: sweep starts at 0 and stalls on user cycles
        do_flip(2, 0, 8'h01);
        do_idle();  chk("R7 sweep at addr0 busy", sweep_busy, 1); chk("R8 no err at addr0", err, 0);
        do_idle();  chk("R8 no err at addr1", err, 0);
        do_read(7); chk("R1 read valid", rd_valid, 1); chk("R10 cleared word", rd_data, 0);
                    chk("R8 sweep stalled during read", err, 0);
        do_idle();  chk("R8 sweep resumes and hits addr2", err, 1); chk("R3 sweep err busy", sweep_busy, 1);
        do_idle();  chk("R9 count after first fix", err_cnt, 1);

        // R1 / R2 / R4
        do_write(3, 8'h5A);
        do_read(3);  chk("R1 read back", rd_data, 8'h5A); chk("R3 clean read no err", err, 0);
        do_flip(3, 1, 8'h0F);
        do_read(3);  chk("R2 vote masks copy1", rd_data, 8'h5A); chk("R3 err on mismatch", err, 1);
        do_idle();   chk("R9 count two", err_cnt, 2);
        do_flip(3, 2, 8'h0F);
        do_read(3);  chk("R4 repaired copy outvotes copy2", rd_data, 8'h5A);
        do_idle();

        // R6 forwarding on back-to-back read
        do_write(5, 8'hC3);
        do_flip(5, 0, 8'hFF);
        do_read(5);  chk("R2 vote masks copy0", rd_data, 8'hC3); chk("R3 err copy0", err, 1);
        do_read(5);  chk("R6 repaired word", rd_data, 8'hC3); chk("R6 no second err", err, 0);
                     chk("R9 single count for one word", err_cnt, 4);

        // R5 user write wins
        do_flip(6, 1, 8'h3C);
        do_read(6);  chk("R3 err copy1 addr6", err, 1);
        do_write(6, 8'hA5);
        do_read(6);  chk("R5 user write kept", rd_data, 8'hA5); chk("R5 no err", err, 0);

        // R11 write and read together
        step(1, 1, 0, AW'(1), 8'h99, 2'd3, '0);
        chk("R11 no read response", rd_valid, 0);
        do_read(1);  chk("R11 write performed", rd_data, 8'h99);

        // R7 background sweep repairs
        do_flip(0, 2, 8'h80);
        pulses = 0;
        for (int i = 0; i < DEPTH + 1; i++) begin
            do_idle();
            if (err) pulses++;
        end
        do_idle();
        chk("R7 sweep found one bad word", pulses, 1);
        do_read(0);  chk("R7 swept word clean", err, 0); chk("R7 swept word data", rd_data, 0);

        // R9 saturation
        for (int i = 0; i < 3; i++) begin
            do_flip(4, 0, 8'h01);
            do_read(4);
            do_idle();
        end
        chk("R9 counter saturates", err_cnt, CMAX);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule